// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose I/O controller for up to twelve pins. It sits on a simple 32-bit register bus with a word address, a write strobe, write data and combinational read data. Software sets the level driven on each pin and whether the pin is driven or left floating. It can read back the synchronised level seen on every pin. A single pass-through select word is also driven out to the pin multiplexing logic.

Every pin has its own event detector. The detector can be set to fire on a falling edge, a rising edge, either edge, a low level or a high level. An event is latched into a per-pin status bit while that pin's enable bit is set. Status bits stay set until software clears them through a write-one-to-clear word. A per-pin mask is set and cleared through two separate write-one words. The masked status can be read back, and its OR forms the single interrupt output. Software scans the status word to find which pins need service. A software reset word holds the whole block at its defaults while its bit 0 is 1.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every word reads 0, except the mask-set word (byte 0x10), which reads all ones over the N_PINS low bits. After reset `irq`, `pin_oe`, `pin_out` and `pin_sel` are 0.
- R2: `pin_oe[n]` equals direction bit n (word 0x20), where 1 means drive. `pin_out[n]` equals output data bit n (word 0x18). Both words read back what was written.
- R3: Word 0x1C returns each pin's input level through a two-flop synchroniser. A change at `pin_in` is visible after the second following rising clock edge. Writes to this word are ignored.
- R4: In the per-pin words (0x00, 0x04, 0x08, 0x10, 0x18, 0x1C, 0x20, 0x38), bits at and above N_PINS always read 0, and writes to those bits have no effect.
- R5: Mode 001 latches status only on a rising pin edge. Mode 000 latches status only on a falling edge. The status bit is visible after the third rising clock edge that follows the pin change.
- R6: Any mode value with bit 2 set latches status on both rising and falling edges.
- R7: Mode 011 latches status while the pin is high, and mode 010 latches it while the pin is low. A clear issued while the level is still active leaves the bit set. Once the level is gone, a clear removes the bit.
- R8: An event on a pin whose enable bit (word 0x00) is 0 does not set its status bit.
- R9: Writing 1 to bit n of word 0x0C clears status bit n, and 0 bits leave status unchanged. When a new event and a clear arrive in the same cycle, the event wins. Status (0x04) is read-only.
- R10: Writing 1 to bit n of word 0x10 masks pin n, and writing 1 to bit n of word 0x14 unmasks it. Zero bits have no effect, and 0x10 reads the current mask. Word 0x08 reads status AND NOT mask, and `irq` is the OR of that value.
- R11: The mode of pin n sits in bits [4k+2:4k]. For pins 0 to 7 this is word 0x24 with k = n. For pins 8 to 11 it is word 0x28 with k = n-8. Bit 4k+3 reads 0, and the nibbles of absent pins read 0.
- R12: Writing 1 to bit 0 of word 0x3C holds every other register at its R1 default from the next cycle onward, and ignores writes to those registers. Writing 0 to that bit releases the block. Word 0x3C reads back bit 0.
- R13: Word 0x38 is stored and driven unchanged onto `pin_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Word address, byte-address bits 5..2 |
| reg_we | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pin_in | input | N_PINS | Pin input levels, asynchronous |
| pin_out | output | N_PINS | Output data to the pin drivers |
| pin_oe | output | N_PINS | Output enable per pin, 1 drives |
| pin_sel | output | N_PINS | Pass-through pin select |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `reg_we` is low whenever no access is meant. They also assume the soft reset bit changes only through a write to word 0x3C. The rule that status holds through an idle cycle therefore applies only when no write is in flight. The bench drives every bus input and pin input at the falling edge, so each pin change passes through the synchroniser before any detector sees it. Random traffic goes only to the output, direction, select and mask words while all enables are 0. Because of that, random data can never create events that the directed edge and level checks do not expect.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_W = 32;

  // word indices (byte offset / 4)
  localparam logic [3:0] W_IEN   = 4'd0;
  localparam logic [3:0] W_STAT  = 4'd1;
  localparam logic [3:0] W_DISP  = 4'd2;
  localparam logic [3:0] W_ICLR  = 4'd3;
  localparam logic [3:0] W_MSET  = 4'd4;
  localparam logic [3:0] W_MCLR  = 4'd5;
  localparam logic [3:0] W_DOUT  = 4'd6;
  localparam logic [3:0] W_DIN   = 4'd7;
  localparam logic [3:0] W_DIR   = 4'd8;
  localparam logic [3:0] W_MODE0 = 4'd9;
  localparam logic [3:0] W_MODE1 = 4'd10;
  localparam logic [3:0] W_USEL  = 4'd14;
  localparam logic [3:0] W_SRST  = 4'd15;

  // low two bits of the mode field when bit 2 is clear
  typedef enum logic [1:0] {
    DET_FALL = 2'b00,
    DET_RISE = 2'b01,
    DET_LOW  = 2'b10,
    DET_HIGH = 2'b11
  } det_kind_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] stab_q, stab_d;

  always_comb begin
    meta_d = async_in;
    stab_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/gpio_pin_det.sv
module gpio_pin_det
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [2:0] mode,
  output logic       evt
);
  logic prev_q, prev_d;

  always_comb begin
    prev_d = lvl;
    if (mode[2]) begin
      evt = lvl ^ prev_q;
    end else begin
      unique case (det_kind_e'(mode[1:0]))
        DET_FALL: evt = prev_q & ~lvl;
        DET_RISE: evt = ~prev_q & lvl;
        DET_LOW:  evt = ~lvl;
        DET_HIGH: evt = lvl;
        default:  evt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:2]        reg_addr,
  input  logic              reg_we,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_PINS-1:0] pin_sel,
  output logic              irq
);
  localparam int NIB_PER_WORD = 8;
  localparam int MODE_W       = 3;
  localparam logic [N_PINS-1:0] ALL_ONES = '1;

  // register state
  logic [N_PINS-1:0] en_q, en_d;
  logic [N_PINS-1:0] st_q, st_d;
  logic [N_PINS-1:0] mask_q, mask_d;
  logic [N_PINS-1:0] dout_q, dout_d;
  logic [N_PINS-1:0] dir_q, dir_d;
  logic [N_PINS-1:0] usel_q, usel_d;
  logic [N_PINS-1:0][MODE_W-1:0] mode_q, mode_d;
  logic srst_q, srst_d;

  logic [15:0]       hit;
  logic [N_PINS-1:0] wd;
  logic [N_PINS-1:0] lvl;
  logic [N_PINS-1:0] evt;
  logic [N_PINS-1:0] disp;
  logic [BUS_W-1:0]  mode_rd0, mode_rd1;
  logic              unused_bits;

  assign hit = reg_we ? (16'd1 << reg_addr) : 16'd0;
  assign wd  = reg_wdata[N_PINS-1:0];
  assign unused_bits = ^{reg_wdata, hit};

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pin_in),
    .sync_out(lvl)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_det
    gpio_pin_det u_det (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (lvl[p]),
      .mode (mode_q[p]),
      .evt  (evt[p])
    );
  end

  // next state
  always_comb begin
    srst_d = hit[W_SRST] ? reg_wdata[0] : srst_q;
    en_d   = en_q;
    mask_d = mask_q;
    dout_d = dout_q;
    dir_d  = dir_q;
    usel_d = usel_q;
    mode_d = mode_q;
    st_d   = st_q;
    if (srst_q) begin
      en_d   = '0;
      mask_d = ALL_ONES;
      dout_d = '0;
      dir_d  = '0;
      usel_d = '0;
      mode_d = '0;
      st_d   = '0;
    end else begin
      if (hit[W_IEN])  en_d   = wd;
      if (hit[W_DOUT]) dout_d = wd;
      if (hit[W_DIR])  dir_d  = wd;
      if (hit[W_USEL]) usel_d = wd;
      if (hit[W_MSET]) mask_d = mask_q | wd;
      if (hit[W_MCLR]) mask_d = mask_q & ~wd;
      for (int i = 0; i < N_PINS; i++) begin
        if ((i < NIB_PER_WORD && hit[W_MODE0]) || (i >= NIB_PER_WORD && hit[W_MODE1]))
          mode_d[i] = reg_wdata[4*(i % NIB_PER_WORD) +: MODE_W];
      end
      st_d = (st_q & ~(hit[W_ICLR] ? wd : '0)) | (evt & en_q);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      st_q   <= '0;
      mask_q <= ALL_ONES;
      dout_q <= '0;
      dir_q  <= '0;
      usel_q <= '0;
      mode_q <= '0;
      srst_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      st_q   <= st_d;
      mask_q <= mask_d;
      dout_q <= dout_d;
      dir_q  <= dir_d;
      usel_q <= usel_d;
      mode_q <= mode_d;
      srst_q <= srst_d;
    end
  end

  // read path
  assign disp = st_q & ~mask_q;

  always_comb begin
    mode_rd0 = '0;
    mode_rd1 = '0;
    for (int i = 0; i < N_PINS; i++) begin
      if (i < NIB_PER_WORD) mode_rd0[4*(i % NIB_PER_WORD) +: MODE_W] = mode_q[i];
      else                  mode_rd1[4*(i % NIB_PER_WORD) +: MODE_W] = mode_q[i];
    end
  end

  always_comb begin
    unique case (reg_addr)
      W_IEN:   reg_rdata = BUS_W'(en_q);
      W_STAT:  reg_rdata = BUS_W'(st_q);
      W_DISP:  reg_rdata = BUS_W'(disp);
      W_MSET:  reg_rdata = BUS_W'(mask_q);
      W_DOUT:  reg_rdata = BUS_W'(dout_q);
      W_DIN:   reg_rdata = BUS_W'(lvl);
      W_DIR:   reg_rdata = BUS_W'(dir_q);
      W_MODE0: reg_rdata = mode_rd0;
      W_MODE1: reg_rdata = mode_rd1;
      W_USEL:  reg_rdata = BUS_W'(usel_q);
      W_SRST:  reg_rdata = BUS_W'(srst_q);
      default: reg_rdata = '0;
    endcase
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
  assign pin_sel = usel_q;
  assign irq     = |disp;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:2]        reg_addr,
  input logic              reg_we,
  input logic [BUS_W-1:0]  reg_rdata,
  input logic              irq,
  input logic [N_PINS-1:0] st_q,
  input logic [N_PINS-1:0] en_q,
  input logic [N_PINS-1:0] mask_q,
  input logic              srst_q
);
  localparam logic [N_PINS-1:0] ALL_ONES = '1;

  logic pin_word;
  assign pin_word = (reg_addr == W_IEN)  || (reg_addr == W_STAT) || (reg_addr == W_DISP) ||
                    (reg_addr == W_MSET) || (reg_addr == W_DOUT) || (reg_addr == W_DIN)  ||
                    (reg_addr == W_DIR)  || (reg_addr == W_USEL);

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && !srst_q) |=> ((st_q & $past(st_q)) == $past(st_q)));  // R9

  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));  // R8

  AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (mask_q == ALL_ONES && en_q == '0 && st_q == '0));  // R12

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == ALL_ONES) |-> !irq);  // R10

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pin_word |-> ((reg_rdata >> N_PINS) == '0));  // R4
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N_PINS(N_PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_we   (reg_we),
  .reg_rdata(reg_rdata),
  .irq      (irq),
  .st_q     (st_q),
  .en_q     (en_q),
  .mask_q   (mask_q),
  .srst_q   (srst_q)
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
  localparam int N = 12;
  localparam logic [31:0] PMASK = 32'h0000_0FFF;
  localparam logic [3:0] A_IEN = 0, A_STAT = 1, A_DISP = 2, A_ICLR = 3, A_MSET = 4,
                         A_MCLR = 5, A_DOUT = 6, A_DIN = 7, A_DIR = 8, A_MODE0 = 9,
                         A_MODE1 = 10, A_USEL = 14, A_SRST = 15;

  logic clk = 0, rst_n = 0;
  logic [5:2] reg_addr = 0;
  logic reg_we = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [N-1:0] pin_in = 0, pin_out, pin_oe, pin_sel;
  logic irq;

  int n_tests = 0, n_fail = 0;
  logic [31:0] v;
  logic [31:0] sh_dout = 0, sh_dir = 0, sh_usel = 0, sh_mask = PMASK;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.N_PINS(N)) i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_sel(pin_sel), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mask_after(input logic [31:0] m, input bit set, input logic [31:0] d);
    return set ? ((m | d) & PMASK) : (m & ~d & PMASK);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_IEN, v);  chk("R1 ien", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_MSET, v); chk("R1 mask", v, PMASK);
    rd(A_MODE0, v); chk("R1 mode0", v, 0);
    chk("R1 outputs", {irq, 8'h0, pin_oe, pin_out}, 0);

    // R4 upper bits
    wr(A_IEN, 32'hFFFF_FFFF); rd(A_IEN, v); chk("R4 ien width", v, PMASK);
    wr(A_IEN, 0);
    // R11 nibble placement
    wr(A_MODE0, 32'hFFFF_FFFF); rd(A_MODE0, v); chk("R11 mode0", v, 32'h7777_7777);
    wr(A_MODE1, 32'hFFFF_FFFF); rd(A_MODE1, v); chk("R11 mode1", v, 32'h0000_7777);
    wr(A_MODE0, 0); wr(A_MODE1, 0);
    // R3 input read-only
    wr(A_DIN, 32'hFFF); rd(A_DIN, v); chk("R3 din ro", v, 0);
    // R13
    wr(A_USEL, 32'h0A5); chk("R13 pin_sel", {20'h0, pin_sel}, 32'h0A5);
    wr(A_USEL, 0);

    // R3 synchroniser latency
    pin_in = 12'h0C0;
    @(posedge clk); @(negedge clk);
    rd(A_DIN, v); chk("R3 after one edge", v, 0);
    settle(1);
    rd(A_DIN, v); chk("R3 after two edges", v, 32'h0C0);
    pin_in = 0; settle(2);

    // modes: p0 rise, p1 high, p2 rise(disabled), p3 both, p4 fall, p5 low, p8 rise
    wr(A_MODE0, 32'h0020_4131);
    wr(A_MODE1, 32'h0000_0001);
    wr(A_IEN, 32'h13B);
    wr(A_ICLR, PMASK);

    // R5 rising
    pin_in[0] = 1; settle(3);
    rd(A_STAT, v); chk("R5 rise sets", v & 32'h11F, 32'h001);
    // R10 masked then unmasked
    chk("R10 masked irq", {31'h0, irq}, 0);
    wr(A_MCLR, 32'h001);
    rd(A_DISP, v); chk("R10 display", v, 32'h001);
    chk("R10 irq up", {31'h0, irq}, 1);
    wr(A_MSET, 32'h001);
    rd(A_MSET, v); chk("R10 mask read", v, PMASK);
    chk("R10 irq down", {31'h0, irq}, 0);
    wr(A_ICLR, 32'h000);
    rd(A_STAT, v); chk("R9 zero clear no effect", v & 32'h11F, 32'h001);
    wr(A_ICLR, 32'h001);
    rd(A_STAT, v); chk("R9 clear", v & 32'h11F, 0);
    pin_in[0] = 0; settle(3);
    rd(A_STAT, v); chk("R5 fall ignored in rise mode", v & 32'h11F, 0);

    // R5 falling pin4
    pin_in[4] = 1; settle(3);
    rd(A_STAT, v); chk("R5 rise ignored in fall mode", v & 32'h11F, 0);
    pin_in[4] = 0; settle(3);
    rd(A_STAT, v); chk("R5 fall sets", v & 32'h11F, 32'h010);
    wr(A_ICLR, 32'h010);

    // R8 disabled pin2
    pin_in[2] = 1; settle(3);
    rd(A_STAT, v); chk("R8 disabled pin", v & 32'h004, 0);
    pin_in[2] = 0; settle(3);

    // R6 both edges pin3
    pin_in[3] = 1; settle(3);
    rd(A_STAT, v); chk("R6 both rise", v & 32'h11F, 32'h008);
    wr(A_ICLR, 32'h008);
    pin_in[3] = 0; settle(3);
    rd(A_STAT, v); chk("R6 both fall", v & 32'h11F, 32'h008);
    wr(A_ICLR, 32'h008);

    // R7 level high pin1
    pin_in[1] = 1; settle(3);
    rd(A_STAT, v); chk("R7 level high", v & 32'h11F, 32'h002);
    wr(A_ICLR, 32'h002);
    rd(A_STAT, v); chk("R7 clear while active", v & 32'h11F, 32'h002);
    pin_in[1] = 0; settle(3);
    wr(A_ICLR, 32'h002);
    rd(A_STAT, v); chk("R7 clear after level gone", v & 32'h11F, 0);
    // R7 level low pin5 (input has been low all along)
    rd(A_STAT, v); chk("R7 level low", v & 32'h020, 32'h020);
    pin_in[5] = 1; settle(3);
    wr(A_ICLR, 32'h020);
    rd(A_STAT, v); chk("R7 level low cleared", v & 32'h020, 0);

    // R11 pin8 in second mode word
    pin_in[8] = 1; settle(3);
    rd(A_STAT, v); chk("R11 pin8 rise", v & 32'h11F, 32'h100);
    wr(A_ICLR, PMASK);
    pin_in = 0;
    wr(A_IEN, 0);
    settle(3);
    wr(A_ICLR, PMASK);

    // random traffic R2 R10 R13
    sh_mask = PMASK;
    for (int it = 0; it < 300; it++) begin
      logic [31:0] d;
      int op;
      d = $urandom;
      op = $urandom_range(0, 4);
      case (op)
        0: begin wr(A_DOUT, d); sh_dout = d & PMASK;
             chk("R2 pin_out", {20'h0, pin_out}, sh_dout);
             rd(A_DOUT, v); chk("R2 dout read", v, sh_dout); end
        1: begin wr(A_DIR, d); sh_dir = d & PMASK;
             chk("R2 pin_oe", {20'h0, pin_oe}, sh_dir);
             rd(A_DIR, v); chk("R2 dir read", v, sh_dir); end
        2: begin wr(A_USEL, d); sh_usel = d & PMASK;
             chk("R13 pin_sel rand", {20'h0, pin_sel}, sh_usel); end
        3: begin wr(A_MSET, d); sh_mask = mask_after(sh_mask, 1, d);
             rd(A_MSET, v); chk("R10 mask set rand", v, sh_mask); end
        default: begin wr(A_MCLR, d); sh_mask = mask_after(sh_mask, 0, d);
             rd(A_MSET, v); chk("R10 mask clr rand", v, sh_mask); end
      endcase
    end

    // R12 soft reset
    wr(A_IEN, 32'h00F);
    wr(A_SRST, 1);
    rd(A_SRST, v); chk("R12 reset readback", v, 1);
    settle(1);
    rd(A_IEN, v);  chk("R12 ien default", v, 0);
    rd(A_MSET, v); chk("R12 mask default", v, PMASK);
    chk("R12 outputs default", {8'h0, pin_sel, pin_oe}, 0);
    wr(A_IEN, 32'h00F);
    rd(A_IEN, v);  chk("R12 write ignored", v, 0);
    wr(A_SRST, 0);
    wr(A_IEN, 32'h005);
    rd(A_IEN, v);  chk("R12 released", v, 32'h005);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule